// File: doc/BRIEF.md
# Four-Phase Instruction Fetch/Execute Sequencer

This block provides timing and pipeline control for a small processor core. It divides the incoming oscillator into four phases, Q1 to Q4. Exactly one phase is active in each oscillator cycle, and the four phases together make one instruction cycle. Each phase carries a fixed set of actions.

During every instruction cycle the block does two things at once. It fetches the word at the current program counter, and it executes the word fetched in the previous cycle. This overlap lets a straight-line instruction finish in one instruction cycle.

The surrounding core supplies three things: the word read from program memory at `pc`, a branch-taken flag and a branch target. The block returns the following:
- the program counter,
- the instruction currently in execute, with a valid flag,
- strobes that tell the datapath when to read an operand and when to write a result.

When a branch is taken, the word already prefetched is turned into a no-op, and the target runs one cycle later. A taken branch therefore costs two instruction cycles.

Top module: `qphase_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `pc` = 0, `exec_valid` = 0, `exec_instr` = NOP_WORD (all zeros by default), `q_phase` = 4'b0001, and every action strobe low.
- R2: `q_phase` is one-hot. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. The active bit advances Q1→Q2→Q3→Q4→Q1 on every clock edge out of reset.
- R3: `pc` is constant within an instruction cycle. Bit 0 of `pc` is always 0. Without a taken branch, `pc` increases by 2, modulo 2^PC_W, at the edge that ends Q4, so the new value is visible from Q1.
- R4: `fetch_word` is sampled at the edge that ends Q4. Without a taken branch, that word is shown on `exec_instr` with `exec_valid` = 1 for the whole next instruction cycle.
- R5: After reset, the first instruction cycle executes a no-op. `pc_inc_stb` and `ir_latch_stb` are high during Q1 of every later instruction cycle, and at no other time.
- R6: `fetch_cap_stb` is high exactly in Q4. `dmem_rd_stb` is high exactly in Q2 when `exec_valid` is 1. `dmem_wr_stb` is high exactly in Q4 when `exec_valid` is 1.
- R7: If `br_taken` is 1 at the edge ending Q4 while `exec_valid` is 1, the next `pc` is `br_target` with bit 0 cleared. The next instruction cycle then has `exec_valid` = 0 and `exec_instr` = NOP_WORD.
- R8: `br_taken` has no effect in Q1, Q2 or Q3. It also has no effect during an instruction cycle whose `exec_valid` is 0.
- R9: The word fetched at a branch target executes, valid, in the instruction cycle after the flushed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_word | input | INSTR_W | Program memory word at `pc` |
| br_taken | input | 1 | Executing instruction redirects the PC |
| br_target | input | PC_W | Branch destination (bit 0 ignored) |
| pc | output | PC_W | Fetch address for the current instruction cycle |
| exec_instr | output | INSTR_W | Instruction in execute (NOP_WORD when flushed) |
| exec_valid | output | 1 | Execute slot holds a real instruction |
| q_phase | output | 4 | One-hot phase, bit 0 = Q1 |
| pc_inc_stb | output | 1 | PC took its next value this cycle (Q1) |
| ir_latch_stb | output | 1 | Execute register took a new word (Q1) |
| fetch_cap_stb | output | 1 | Fetch word is being sampled (Q4) |
| dmem_rd_stb | output | 1 | Operand read phase (Q2, valid slot) |
| dmem_wr_stb | output | 1 | Destination write phase (Q4, valid slot) |

## Verification
The hardest cases to reach are those where a branch request arrives when it must be ignored. One is a request during the flushed slot that follows a taken branch. The other is a request in a phase other than Q4. The bench drives `br_taken` from a pseudo-random sequence in every oscillator cycle, whatever the phase. Back-to-back requests therefore regularly land in flushed slots and in Q1 to Q3. Targets are drawn from a mix that includes odd addresses, zero and the top of the address space, which exercises the bit-0 clearing and the wrap of the step. A second reset partway through the run restarts the sequence from an arbitrary phase.

// File: rtl/qs_pkg.sv
// Package: shared phase type and counts for the four-phase sequencer.
// Assumes a fixed four-phase instruction cycle.
package qs_pkg;
    localparam int NUM_PHASES = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } qs_phase_e;
endpackage

// File: rtl/qs_phase_gen.sv
// Phase generator: a free-running modulo-4 counter, decoded into one-hot
// phase strobes. It also raises a 'run' flag once the first instruction
// cycle after reset has ended.
// Assumes a synchronous active-low reset that parks the counter on Q1.
module qs_phase_gen
    import qs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output qs_phase_e             phase,
    output logic [NUM_PHASES-1:0] q_onehot,
    output logic                  run
);
    qs_phase_e ph_q;
    logic      run_q;

    // Advance the phase once per oscillator cycle, wrapping after Q4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_Q1;
        end else begin
            case (ph_q)
                PH_Q1:   ph_q <= PH_Q2;
                PH_Q2:   ph_q <= PH_Q3;
                PH_Q3:   ph_q <= PH_Q4;
                default: ph_q <= PH_Q1;
            endcase
        end
    end

    // Mark that at least one instruction cycle has completed.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= 1'b0;
        else if (ph_q == PH_Q4)  run_q <= 1'b1;
    end

    // One decoder per phase bit.
    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_dec
        assign q_onehot[i] = (ph_q == qs_phase_e'(i));
    end

    assign phase = ph_q;
    assign run   = run_q;

    // R2: exactly one phase is active in every cycle.
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_onehot) == 1);
    // R2: Q4 is always followed by Q1.
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_onehot[3] |=> q_onehot[0]);
    // R2: Q1 is always followed by Q2.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_onehot[0] |=> q_onehot[1]);
endmodule

// File: rtl/qs_pc_unit.sv
// Program counter: holds the fetch address for one instruction cycle.
// At the end of Q4 it either steps to the next word or loads a branch
// target. Only the upper PC_W-1 bits are stored, so bit 0 is always 0.
// Assumes 'end_cycle' is high for exactly one clock per instruction cycle.
module qs_pc_unit #(
    parameter int PC_W = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            end_cycle,
    input  logic            take_br,
    input  logic [PC_W-1:0] br_target,
    output logic [PC_W-1:0] pc
);
    localparam int HI_W = PC_W - 1;

    logic [HI_W-1:0] pc_hi_q;

    // Step by one word (two address units) or load the target at Q4's end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_hi_q <= '0;
        end else if (end_cycle) begin
            if (take_br) pc_hi_q <= br_target[PC_W-1:1];
            else         pc_hi_q <= pc_hi_q + HI_W'(1);
        end
    end

    assign pc = {pc_hi_q, 1'b0};

    // R3: pc never changes except at an instruction-cycle boundary.
    p_pc_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !end_cycle |=> $stable(pc));
    // R3: the sequential step is +2 with wrap.
    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cycle && !take_br) |=> pc == $past(pc) + PC_W'(2));
    // R7: a taken branch loads the even-aligned target.
    p_br_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cycle && take_br) |=> pc == {$past(br_target[PC_W-1:1]), 1'b0});
endmodule

// File: rtl/qs_pipe.sv
// Execute-stage register: samples the fetched word at the end of Q4 and
// presents it for the next instruction cycle. A taken branch marks the
// captured slot invalid, and it is then shown as NOP_WORD.
// Assumes 'take_br' is already qualified with the current slot's validity.
module qs_pipe #(
    parameter int                   INSTR_W  = 16,
    parameter logic [INSTR_W-1:0]   NOP_WORD = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               end_cycle,
    input  logic               take_br,
    input  logic [INSTR_W-1:0] fetch_word,
    output logic [INSTR_W-1:0] exec_instr,
    output logic               exec_valid
);
    logic [INSTR_W-1:0] ir_q;
    logic               valid_q;

    // Capture the prefetched word and decide whether it survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q    <= NOP_WORD;
            valid_q <= 1'b0;
        end else if (end_cycle) begin
            ir_q    <= fetch_word;
            valid_q <= !take_br;
        end
    end

    // A squashed slot is presented as the no-op encoding.
    always_comb begin
        exec_instr = valid_q ? ir_q : NOP_WORD;
        exec_valid = valid_q;
    end

    // R7: a taken branch squashes the next execute slot.
    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cycle && take_br) |=> (!exec_valid && exec_instr == NOP_WORD));
    // R4: without a branch, the sampled word is executed next.
    p_ir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cycle && !take_br) |=> (exec_valid && exec_instr == $past(fetch_word)));
    // R4: the execute slot holds steady inside an instruction cycle.
    p_ir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !end_cycle |=> ($stable(exec_instr) && $stable(exec_valid)));
endmodule

// File: rtl/qphase_seq.sv
// Top: four-phase fetch/execute sequencer. It ties the phase generator,
// program counter and execute register together, qualifies branch
// requests (Q4 only, valid slot only) and forms the per-phase strobes.
// Assumes program memory returns fetch_word for 'pc' within the same
// instruction cycle, stable by the end of Q4.
module qphase_seq #(
    parameter int                 PC_W     = 21,
    parameter int                 INSTR_W  = 16,
    parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] fetch_word,
    input  logic               br_taken,
    input  logic [PC_W-1:0]    br_target,
    output logic [PC_W-1:0]    pc,
    output logic [INSTR_W-1:0] exec_instr,
    output logic               exec_valid,
    output logic [3:0]         q_phase,
    output logic               pc_inc_stb,
    output logic               ir_latch_stb,
    output logic               fetch_cap_stb,
    output logic               dmem_rd_stb,
    output logic               dmem_wr_stb
);
    import qs_pkg::*;

    qs_phase_e             phase;
    logic [NUM_PHASES-1:0] q_oh;
    logic                  run;
    logic                  end_cycle;
    logic                  take_br;

    qs_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .q_onehot (q_oh),
        .run      (run)
    );

    // Branch requests count only at the end of a valid execute slot.
    always_comb begin
        end_cycle = (phase == PH_Q4);
        take_br   = end_cycle && exec_valid && br_taken;
    end

    qs_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_cycle (end_cycle),
        .take_br   (take_br),
        .br_target (br_target),
        .pc        (pc)
    );

    qs_pipe #(.INSTR_W(INSTR_W), .NOP_WORD(NOP_WORD)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .end_cycle  (end_cycle),
        .take_br    (take_br),
        .fetch_word (fetch_word),
        .exec_instr (exec_instr),
        .exec_valid (exec_valid)
    );

    // Per-phase action strobes.
    always_comb begin
        q_phase       = q_oh;
        pc_inc_stb    = q_oh[0] && run;
        ir_latch_stb  = q_oh[0] && run;
        fetch_cap_stb = q_oh[3];
        dmem_rd_stb   = q_oh[1] && exec_valid;
        dmem_wr_stb   = q_oh[3] && exec_valid;
    end

    // R6: the write strobe needs a valid slot and phase Q4.
    p_wr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_wr_stb |-> (exec_valid && q_phase[3]));
    // R6: the read strobe needs a valid slot and phase Q2.
    p_rd_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd_stb |-> (exec_valid && q_phase[1]));
    // R8: a request during a flushed slot leaves the sequential step intact.
    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_phase[3] && !exec_valid && br_taken) |=> (exec_valid && pc == $past(pc) + PC_W'(2)));
    // R5: the PC/IR strobes fire only in Q1.
    p_q1_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc_stb || ir_latch_stb) |-> q_phase[0]);
endmodule

// File: tb/qphase_seq_tb.sv
module qphase_seq_tb;
    localparam int PC_W    = 21;
    localparam int INSTR_W = 16;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [INSTR_W-1:0] fetch_word;
    logic               br_taken;
    logic [PC_W-1:0]    br_target;
    logic [PC_W-1:0]    pc;
    logic [INSTR_W-1:0] exec_instr;
    logic               exec_valid;
    logic [3:0]         q_phase;
    logic               pc_inc_stb, ir_latch_stb, fetch_cap_stb;
    logic               dmem_rd_stb, dmem_wr_stb;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    // Program memory model: a nonzero word derived from the address.
    function automatic logic [INSTR_W-1:0] word_at(input logic [PC_W-1:0] a);
        return {a[15:1] ^ 15'h2A5A, 1'b1};
    endfunction

    assign fetch_word = word_at(pc);

    qphase_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_word    (fetch_word),
        .br_taken      (br_taken),
        .br_target     (br_target),
        .pc            (pc),
        .exec_instr    (exec_instr),
        .exec_valid    (exec_valid),
        .q_phase       (q_phase),
        .pc_inc_stb    (pc_inc_stb),
        .ir_latch_stb  (ir_latch_stb),
        .fetch_cap_stb (fetch_cap_stb),
        .dmem_rd_stb   (dmem_rd_stb),
        .dmem_wr_stb   (dmem_wr_stb)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // reference state
        int              e_ph;
        logic [PC_W-1:0] e_pc;
        logic [15:0]     e_ir;
        logic            e_v, e_run, e_inrst;
        logic            ign_seen;
        string           pc_tag, ir_tag;
        logic [15:0]     lfsr;
        logic            nrst, nbr;
        logic [PC_W-1:0] ntgt;

        rst_n = 1'b0; br_taken = 1'b0; br_target = '0;
        e_ph = 0; e_pc = '0; e_ir = 16'h0; e_v = 1'b0; e_run = 1'b0;
        e_inrst = 1'b1; ign_seen = 1'b0;
        pc_tag = "R1"; ir_tag = "R1";
        lfsr = 16'hACE1;
        @(posedge clk);

        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            // ---- checks against the reference state ----
            check(e_inrst ? "R1" : "R2", "q_phase", 32'(q_phase), 32'(4'b0001 << e_ph));
            check(pc_tag, "pc", 32'(pc), 32'(e_pc));
            check("R3", "pc bit0", 32'(pc[0]), 32'd0);
            check(ir_tag, "exec_valid", 32'(exec_valid), 32'(e_v));
            check(ir_tag, "exec_instr", 32'(exec_instr), 32'(e_v ? e_ir : 16'h0));
            check(e_inrst ? "R1" : "R5", "pc_inc_stb", 32'(pc_inc_stb), 32'(e_ph == 0 && e_run));
            check(e_inrst ? "R1" : "R5", "ir_latch_stb", 32'(ir_latch_stb), 32'(e_ph == 0 && e_run));
            check("R6", "fetch_cap_stb", 32'(fetch_cap_stb), 32'(e_ph == 3));
            check("R6", "dmem_rd_stb", 32'(dmem_rd_stb), 32'(e_ph == 1 && e_v));
            check("R6", "dmem_wr_stb", 32'(dmem_wr_stb), 32'(e_ph == 3 && e_v));

            // ---- choose next inputs ----
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            nrst = !(cyc < 4 || (cyc >= 1501 && cyc < 1504));
            nbr  = (lfsr[2:0] < 3'd3);
            case (lfsr[5:4])
                2'd0: ntgt = {lfsr[4:0], lfsr};
                2'd1: ntgt = 21'h1FFFFF;
                2'd2: ntgt = 21'h000000;
                default: ntgt = 21'h000003;
            endcase

            // ---- advance the reference model over the coming edge ----
            if (!nrst) begin
                e_ph = 0; e_pc = '0; e_ir = 16'h0; e_v = 1'b0; e_run = 1'b0;
                e_inrst = 1'b1; ign_seen = 1'b0;
                pc_tag = "R1"; ir_tag = "R1";
            end else begin
                e_inrst = 1'b0;
                if (e_ph == 3) begin
                    e_run = 1'b1;
                    e_ir  = word_at(e_pc);
                    if (e_v && nbr) begin
                        e_pc   = {ntgt[PC_W-1:1], 1'b0};
                        e_v    = 1'b0;
                        pc_tag = "R7";
                        ir_tag = "R7";
                    end else begin
                        if (nbr) ign_seen = 1'b1;
                        ir_tag = (pc_tag == "R7") ? "R9" : (e_run ? "R4" : "R5");
                        e_pc   = e_pc + 21'd2;
                        e_v    = 1'b1;
                        pc_tag = ign_seen ? "R8" : "R3";
                    end
                    ign_seen = 1'b0;
                    e_ph = 0;
                end else begin
                    if (nbr) ign_seen = 1'b1;
                    e_ph = e_ph + 1;
                end
            end

            rst_n     = nrst;
            br_taken  = nbr;
            br_target = ntgt;
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule